// File: doc/BRIEF.md
# Burst-Capable Operand and Result Register Window

This block is a memory-mapped slave with full read and write channels (address, data and response), a 32-bit byte address and 64-bit data beats. Behind the bus sits a small fixed structure: an eight-byte scratch array, two 32-bit operands, a 64-bit sum, a 32-bit XOR result, a 32-bit OR result and a one-bit control flag. A host writes operands over the bus and pulses `start`. A small kernel then computes the zero-extended sum, the bitwise XOR and the bitwise OR of the operands and pulses `finish`. The host reads the results back over the same bus.

Reads and writes run on separate state machines and may overlap. Every burst is treated as incrementing, with eight bytes per beat, whatever burst-type and size codes arrive with the address. Byte strobes act per structure field: a field changes only when every strobe bit that covers it is set.

Read machine: `RD_IDLE` (address accepted) → `RD_BEAT` (beats returned; returns to `RD_IDLE` after the last beat is taken). Write machine: `WR_IDLE` (address accepted) → `WR_DATA` (beats accepted; moves on when the beat flagged last is taken) → `WR_RESP` (one response; returns to `WR_IDLE` when it is taken). Kernel: `K_IDLE` (ready) → `K_CALC` (operands latched) → `K_DONE` (results stored, finish high) → `K_IDLE`.

Top module: `regbank_axi_slave`

## Requirements
- R1: After reset, `ar_ready`, `aw_ready` and `ready` are 1, `r_valid`, `w_ready`, `b_valid` and `finish` are 0, and every word reads as zero.
- R2: The word index is the byte address shifted right by 3. Word 0 is the byte array (byte k in bits 8k+7:8k). Word 1 holds operand A in bits 31:0 and operand B in bits 63:32. Word 2 is the sum. Word 3 holds XOR in bits 31:0 and OR in bits 63:32. Word 4 holds the flag in bit 0. Read response is always 0 (OKAY).
- R3: A read with length field L returns L+1 beats. `r_last` is set on the final beat only. No beat follows it.
- R4: The burst-type and size inputs on both address channels have no effect. Every beat advances the word index by one.
- R5: Word 0 bytes are written per strobe bit. On word 1, A changes only if strobe bits 3:0 are all 1, and B changes only if bits 7:4 are all 1. The flag changes only if strobe bit 0 is 1.
- R6: Writes to words 2, 3 and any word at index 5 or above are dropped. Reads of words at index 5 or above return zero.
- R7: Exactly one write response, with `b_resp` = 0, follows the beat carrying `w_last`. It stays valid until `b_ready`.
- R8: A `start` seen while `ready` is 1 makes `finish` 1 for exactly one cycle, two cycles later. From then on the result words hold the 64-bit zero-extended A+B, A^B and A|B.
- R9: `ready` is 0 from the cycle after an accepted `start` until `finish` has been shown. A `start` during that time is ignored.
- R10: A write burst stores its beats at consecutive word indices starting at the address's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Kernel launch request |
| ready | output | 1 | Kernel idle |
| finish | output | 1 | One-cycle kernel completion pulse |
| ar_addr | input | ADDR_W | Read byte address |
| ar_burst | input | 2 | Read burst type (ignored) |
| ar_size | input | 3 | Read beat size (ignored) |
| ar_len | input | LEN_W | Read beats minus one |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| r_data | output | 64 | Read beat data |
| r_resp | output | 2 | Read response, always 0 |
| r_last | output | 1 | Final read beat |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat taken |
| aw_addr | input | ADDR_W | Write byte address |
| aw_burst | input | 2 | Write burst type (ignored) |
| aw_size | input | 3 | Write beat size (ignored) |
| aw_len | input | LEN_W | Write beats minus one (informational) |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted |
| w_data | input | 64 | Write beat data |
| w_strb | input | 8 | Write byte strobes |
| w_last | input | 1 | Final write beat |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat accepted |
| b_resp | output | 2 | Write response, always 0 |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |

## Verification
The bench builds the block with its default parameters: a 32-bit address and an 8-bit length field. A single burst can therefore sweep every mapped word and run into the unmapped area. Bursts of one, two and six beats are used, which covers the first-beat, last-beat and hold-under-backpressure paths of the read machine. The kernel's sum of 9 and 0xFFFFFFFE produces a carry out of bit 31, so the zero extension into bit 32 is visible.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int DATA_W = 64;
    localparam int STRB_W = DATA_W / 8;
    localparam int OP_W   = 32;
    localparam int BEAT_SHIFT = 3;

    localparam int WORD_ARR   = 0;
    localparam int WORD_OPS   = 1;
    localparam int WORD_SUM   = 2;
    localparam int WORD_LOGIC = 3;
    localparam int WORD_CTRL  = 4;

    typedef enum logic {RD_IDLE, RD_BEAT} rd_state_t;
    typedef enum logic [1:0] {WR_IDLE, WR_DATA, WR_RESP} wr_state_t;
    typedef enum logic [1:0] {K_IDLE, K_CALC, K_DONE} k_state_t;
endpackage

// File: rtl/regbank_rd_fsm.sv
module regbank_rd_fsm
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [LEN_W-1:0]  ar_len,
    input  logic              ar_valid,
    output logic              ar_ready,
    output logic              r_valid,
    input  logic              r_ready,
    output logic              r_last,
    output logic [ADDR_W-1:0] rd_word
);
    rd_state_t         state_q;
    logic [ADDR_W-1:0] word_q;
    logic [LEN_W-1:0]  lenm1_q;
    logic [LEN_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            word_q  <= '0;
            lenm1_q <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                RD_IDLE: if (ar_valid) begin
                    state_q <= RD_BEAT;
                    word_q  <= ar_addr >> BEAT_SHIFT;
                    lenm1_q <= ar_len;
                    cnt_q   <= '0;
                end
                RD_BEAT: if (r_ready) begin
                    word_q <= word_q + 1'b1;
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == lenm1_q) state_q <= RD_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        ar_ready = 1'b0;
        r_valid  = 1'b0;
        unique case (state_q)
            RD_IDLE: ar_ready = 1'b1;
            RD_BEAT: r_valid  = 1'b1;
        endcase
        r_last  = r_valid && (cnt_q == lenm1_q);
        rd_word = word_q;
    end

    assert_last_ends_burst_R3: assert property (@(posedge clk) disable iff (rst)
        (r_valid && r_ready && r_last) |=> !r_valid);
    assert_beat_held_R3: assert property (@(posedge clk) disable iff (rst)
        (r_valid && !r_ready) |=> (r_valid && $stable(rd_word) && $stable(r_last)));
endmodule

// File: rtl/regbank_wr_fsm.sv
module regbank_wr_fsm
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic              w_valid,
    input  logic              w_last,
    output logic              w_ready,
    output logic              b_valid,
    input  logic              b_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_word
);
    wr_state_t         state_q;
    logic [ADDR_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WR_IDLE;
            word_q  <= '0;
        end else begin
            unique case (state_q)
                WR_IDLE: if (aw_valid) begin
                    state_q <= WR_DATA;
                    word_q  <= aw_addr >> BEAT_SHIFT;
                end
                WR_DATA: if (w_valid) begin
                    word_q <= word_q + 1'b1;
                    if (w_last) state_q <= WR_RESP;
                end
                WR_RESP: if (b_ready) state_q <= WR_IDLE;
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    always_comb begin
        aw_ready = 1'b0;
        w_ready  = 1'b0;
        b_valid  = 1'b0;
        unique case (state_q)
            WR_IDLE: aw_ready = 1'b1;
            WR_DATA: w_ready  = 1'b1;
            WR_RESP: b_valid  = 1'b1;
            default: ;
        endcase
        wr_en   = w_ready && w_valid;
        wr_word = word_q;
    end

    assert_resp_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (w_valid && w_ready && w_last) |=> b_valid);
    assert_resp_held_R7: assert property (@(posedge clk) disable iff (rst)
        (b_valid && !b_ready) |=> b_valid);
endmodule

// File: rtl/regbank_kernel.sv
module regbank_kernel
    import regbank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [OP_W-1:0]     opa,
    input  logic [OP_W-1:0]     opb,
    output logic                ready,
    output logic                finish,
    output logic [DATA_W-1:0]   sum_q,
    output logic [OP_W-1:0]     xor_q,
    output logic [OP_W-1:0]     or_q
);
    k_state_t        state_q;
    logic [OP_W-1:0] a_q, b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= K_IDLE;
            a_q     <= '0;
            b_q     <= '0;
            sum_q   <= '0;
            xor_q   <= '0;
            or_q    <= '0;
        end else begin
            unique case (state_q)
                K_IDLE: if (start) begin
                    a_q     <= opa;
                    b_q     <= opb;
                    state_q <= K_CALC;
                end
                K_CALC: begin
                    sum_q   <= {{(DATA_W-OP_W){1'b0}}, a_q} + {{(DATA_W-OP_W){1'b0}}, b_q};
                    xor_q   <= a_q ^ b_q;
                    or_q    <= a_q | b_q;
                    state_q <= K_DONE;
                end
                K_DONE: state_q <= K_IDLE;
                default: state_q <= K_IDLE;
            endcase
        end
    end

    always_comb begin
        ready  = 1'b0;
        finish = 1'b0;
        unique case (state_q)
            K_IDLE: ready  = 1'b1;
            K_CALC: ;
            K_DONE: finish = 1'b1;
            default: ;
        endcase
    end

    assert_finish_single_R8: assert property (@(posedge clk) disable iff (rst)
        finish |=> !finish);
    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> !ready);
endmodule

// File: rtl/regbank_axi_slave.sv
module regbank_axi_slave
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              ready,
    output logic              finish,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [1:0]        ar_burst,
    input  logic [2:0]        ar_size,
    input  logic [LEN_W-1:0]  ar_len,
    input  logic              ar_valid,
    output logic              ar_ready,
    output logic [63:0]       r_data,
    output logic [1:0]        r_resp,
    output logic              r_last,
    output logic              r_valid,
    input  logic              r_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [1:0]        aw_burst,
    input  logic [2:0]        aw_size,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [63:0]       w_data,
    input  logic [7:0]        w_strb,
    input  logic              w_last,
    input  logic              w_valid,
    output logic              w_ready,
    output logic [1:0]        b_resp,
    output logic              b_valid,
    input  logic              b_ready
);
    logic [DATA_W-1:0] arr_q;
    logic [OP_W-1:0]   opa_q, opb_q;
    logic              flag_q;
    logic [DATA_W-1:0] sum_w;
    logic [OP_W-1:0]   xor_w, or_w;
    logic [ADDR_W-1:0] rd_word, wr_word;
    logic              wr_en;

    logic unused_sideband;
    assign unused_sideband = ^{ar_burst, ar_size, aw_burst, aw_size, aw_len,
                               ar_addr[BEAT_SHIFT-1:0], aw_addr[BEAT_SHIFT-1:0]};

    regbank_rd_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) rd_i (
        .clk(clk), .rst(rst), .ar_addr(ar_addr), .ar_len(ar_len),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .r_valid(r_valid),
        .r_ready(r_ready), .r_last(r_last), .rd_word(rd_word));

    regbank_wr_fsm #(.ADDR_W(ADDR_W)) wr_i (
        .clk(clk), .rst(rst), .aw_addr(aw_addr), .aw_valid(aw_valid),
        .aw_ready(aw_ready), .w_valid(w_valid), .w_last(w_last),
        .w_ready(w_ready), .b_valid(b_valid), .b_ready(b_ready),
        .wr_en(wr_en), .wr_word(wr_word));

    regbank_kernel kern_i (
        .clk(clk), .rst(rst), .start(start), .opa(opa_q), .opb(opb_q),
        .ready(ready), .finish(finish), .sum_q(sum_w), .xor_q(xor_w), .or_q(or_w));

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_q  <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            flag_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_word)
                WORD_ARR: for (int i = 0; i < STRB_W; i++)
                    if (w_strb[i]) arr_q[i*8 +: 8] <= w_data[i*8 +: 8];
                WORD_OPS: begin
                    if (&w_strb[STRB_W/2-1:0])      opa_q <= w_data[OP_W-1:0];
                    if (&w_strb[STRB_W-1:STRB_W/2]) opb_q <= w_data[DATA_W-1:OP_W];
                end
                WORD_CTRL: if (w_strb[0]) flag_q <= w_data[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_word)
            WORD_ARR:   r_data = arr_q;
            WORD_OPS:   r_data = {opb_q, opa_q};
            WORD_SUM:   r_data = sum_w;
            WORD_LOGIC: r_data = {or_w, xor_w};
            WORD_CTRL:  r_data = {{(DATA_W-1){1'b0}}, flag_q};
            default:    r_data = '0;
        endcase
        r_resp = 2'b00;
        b_resp = 2'b00;
    end
endmodule

// File: tb/regbank_axi_slave_tb.sv
module regbank_axi_slave_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic start = 0, ready, finish;
    logic [31:0] ar_addr = 0, aw_addr = 0;
    logic [1:0]  ar_burst = 1, aw_burst = 1;
    logic [2:0]  ar_size = 3, aw_size = 3;
    logic [7:0]  ar_len = 0, aw_len = 0;
    logic ar_valid = 0, ar_ready, r_last, r_valid, r_ready = 0;
    logic [63:0] r_data;
    logic [1:0]  r_resp, b_resp;
    logic aw_valid = 0, aw_ready, w_last = 0, w_valid = 0, w_ready, b_valid, b_ready = 0;
    logic [63:0] w_data = 0;
    logic [7:0]  w_strb = 0;

    regbank_axi_slave dut_i (.*);

    int checks = 0, fails = 0;
    bit done = 0;
    logic [63:0] wdat [8];
    logic [7:0]  wstb [8];
    logic [63:0] rdat [8];
    logic        rlst [8];

    // word, data, strobe, expected read-back
    localparam int NV = 11;
    localparam logic [143:0] VEC [NV] = '{
        {8'd0, 64'h1122334455667788, 8'hFF, 64'h1122334455667788},
        {8'd0, 64'hAAAAAAAAAAAAAAAA, 8'h0F, 64'h11223344AAAAAAAA},
        {8'd1, 64'h0000000500000007, 8'hFF, 64'h0000000500000007},
        {8'd1, 64'h12345678FFFFFFFF, 8'h7F, 64'h00000005FFFFFFFF},
        {8'd1, 64'hFFFFFFFE00000000, 8'hF0, 64'hFFFFFFFEFFFFFFFF},
        {8'd1, 64'h0000000300000009, 8'h3F, 64'hFFFFFFFE00000009},
        {8'd4, 64'hFFFFFFFFFFFFFFFF, 8'h01, 64'h0000000000000001},
        {8'd4, 64'h0000000000000000, 8'h02, 64'h0000000000000001},
        {8'd2, 64'h000000000000DEAD, 8'hFF, 64'h0000000000000000},
        {8'd3, 64'h0000000000001234, 8'hFF, 64'h0000000000000000},
        {8'd7, 64'h0000000000000055, 8'hFF, 64'h0000000000000000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_burst(input logic [31:0] addr, input int n, input logic [1:0] bt, input logic [2:0] sz);
        @(negedge clk);
        aw_addr = addr; aw_len = 8'(n - 1); aw_burst = bt; aw_size = sz; aw_valid = 1;
        while (!aw_ready) @(negedge clk);
        @(negedge clk);
        aw_valid = 0;
        for (int i = 0; i < n; i++) begin
            w_data = wdat[i]; w_strb = wstb[i]; w_last = (i == n - 1); w_valid = 1;
            while (!w_ready) @(negedge clk);
            @(negedge clk);
        end
        w_valid = 0; w_last = 0; b_ready = 1;
        while (!b_valid) @(negedge clk);
        chk("R7 bresp", {62'd0, b_resp}, 64'd0);
        @(negedge clk);
        b_ready = 0;
        chk("R7 single response", {63'd0, b_valid}, 64'd0);
    endtask

    task automatic rd_burst(input logic [31:0] addr, input int n, input logic [1:0] bt, input logic [2:0] sz, input bit gap);
        @(negedge clk);
        ar_addr = addr; ar_len = 8'(n - 1); ar_burst = bt; ar_size = sz; ar_valid = 1;
        while (!ar_ready) @(negedge clk);
        @(negedge clk);
        ar_valid = 0; r_ready = 1;
        for (int i = 0; i < n; i++) begin
            if (gap) begin r_ready = 0; @(negedge clk); r_ready = 1; end
            while (!r_valid) @(negedge clk);
            rdat[i] = r_data; rlst[i] = r_last;
            if (r_resp !== 2'b00) chk("R2 rresp", {62'd0, r_resp}, 64'd0);
            @(negedge clk);
        end
        r_ready = 0;
        chk("R3 no beat after last", {63'd0, r_valid}, 64'd0);
    endtask

    task automatic kick;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ar_ready", {63'd0, ar_ready}, 64'd1);
        chk("R1 aw_ready", {63'd0, aw_ready}, 64'd1);
        chk("R1 idle outputs", {59'd0, r_valid, w_ready, b_valid, finish, ~ready}, 64'd0);
        rd_burst(32'h0, 5, 2'b01, 3'd3, 0);
        for (int i = 0; i < 5; i++) chk("R1 word zero", rdat[i], 64'd0);

        // R5 R6 vector table
        for (int v = 0; v < NV; v++) begin
            wdat[0] = VEC[v][135:72]; wstb[0] = VEC[v][71:64];
            wr_burst({21'd0, VEC[v][143:136], 3'b000}, 1, 2'b01, 3'd3);
            rd_burst({21'd0, VEC[v][143:136], 3'b000}, 1, 2'b01, 3'd3, 0);
            if (VEC[v][143:136] inside {8'd0, 8'd1, 8'd4})
                chk("R5 strobe groups", rdat[0], VEC[v][63:0]);
            else
                chk("R6 dropped/unmapped", rdat[0], VEC[v][63:0]);
        end

        // R8 kernel timing and results: a=9, b=FFFFFFFE
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R9 ready low while busy", {62'd0, ready, finish}, 64'd0);
        @(negedge clk);
        chk("R8 finish pulse", {62'd0, ready, finish}, 64'd1);
        @(negedge clk);
        chk("R8 finish single", {62'd0, ready, finish}, 64'd2);

        // R2 R3 R4 six-beat read, odd address, ignored burst/size codes, backpressure
        rd_burst(32'h3, 6, 2'b00, 3'd0, 1);
        chk("R2 word0", rdat[0], 64'h11223344AAAAAAAA);
        chk("R2 word1", rdat[1], 64'hFFFFFFFE00000009);
        chk("R8 sum carry", rdat[2], 64'h0000000100000007);
        chk("R8 xor/or", rdat[3], 64'hFFFFFFFFFFFFFFF7);
        chk("R2 flag", rdat[4], 64'd1);
        chk("R6 unmapped read", rdat[5], 64'd0);
        chk("R3 last flags", {58'd0, rlst[5], rlst[4], rlst[3], rlst[2], rlst[1], rlst[0]}, 64'h20);

        // R10 R4 two-beat write with odd burst/size codes
        wdat[0] = 64'h0102030405060708; wstb[0] = 8'hFF;
        wdat[1] = 64'h0000000200000003; wstb[1] = 8'hFF;
        wr_burst(32'h0, 2, 2'b10, 3'd1);
        rd_burst(32'h0, 2, 2'b01, 3'd3, 0);
        chk("R10 beat0", rdat[0], 64'h0102030405060708);
        chk("R10 beat1", rdat[1], 64'h0000000200000003);

        // R9 start held across busy cycle: exactly one finish
        begin
            int nfin = 0;
            @(negedge clk); start = 1;
            @(negedge clk);
            chk("R9 busy", {63'd0, ready}, 64'd0);
            @(negedge clk); start = 0;
            for (int k = 0; k < 6; k++) begin
                nfin += int'(finish);
                @(negedge clk);
            end
            chk("R9 one finish", 64'(nfin), 64'd1);
            chk("R9 ready again", {63'd0, ready}, 64'd1);
        end
        rd_burst(32'h10, 2, 2'b01, 3'd3, 0);
        chk("R8 sum", rdat[0], 64'd5);
        chk("R8 xor/or", rdat[1], 64'h0000000300000001);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule